// File: doc/BRIEF.md
# Card Clock and Operation Control

This block produces the bus clock for a memory-card port and owns the small strobe register that software uses to run it. The card clock is derived by a power-of-two divider from the reference. The block is clocked by a core clock at twice the 24 MHz reference rate, so each half period of the card clock is a whole number of core cycles, even when the divider is zero. With a divider value d, one card clock period lasts 2^(d+1) core cycles, which is the reference rate shifted right by d.

Software writes command strobes to the low byte of a 16-bit control register. The upper byte is reserved and is not brought into the block. Each strobe acts once and is then forgotten, so the register reads back as zero. A stop request is held until the card clock is in its low phase, so no clipped high pulse reaches the card. Software can poll the running flag until the clock has truly halted. A soft reset runs for a fixed count, and its progress is shown by a busy flag. A start-op strobe is passed to the command engine as a single-cycle pulse, but only when it arrives in the same write as a clock start. The four read-wait and exit strobes are decoded into their own single-cycle pulses.

Top module: `card_clk_ctrl`

## Requirements
- R1: With divider value d (0 to 7), the card clock period is 2^(d+1) core cycles, and the first high phase after a start begins 2^d cycles after the start write.
- R2: The control byte is decoded by bit position: bit 0 stops the clock, bit 1 starts it, bit 2 starts an operation and bit 3 requests a soft reset.
- R3: Status bit 8 is 1 from the cycle after an accepted start until a stop has taken effect, and is 0 after reset.
- R4: A stop that arrives while the card clock is high takes effect when the high phase ends, so the high phase keeps its full 2^d cycles. A stop that arrives while the clock is low takes effect at once. After a stop the card clock stays low.
- R5: The operation-start output pulses high for one cycle after a write that sets bits 1 and 2 together. A write that sets bit 2 without bit 1 produces no pulse.
- R6: A soft reset holds status bit 15 high for 16 core cycles (8 reference periods), stops the clock, clears the divider to 0, and ignores all control and divider writes made while it runs.
- R7: Control bits 4, 5, 6 and 7 each produce a one-cycle pulse on auxiliary output bits 0, 1, 2 and 3 in the cycle after the write.
- R8: The control read-back value is always 0.
- R9: A divider write made while the clock runs leaves the current period unchanged and takes effect at the next rising edge of the card clock.
- R10: A write that sets both stop and start is treated as a stop only: the clock does not start and no operation pulse is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, twice the reference rate |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 8 | Low byte of the control write |
| div_wr_i | input | 1 | Divider write strobe |
| div_wdata_i | input | 3 | Divider shift value |
| ctrl_rdata_o | output | 16 | Control read-back, always zero |
| status_o | output | 16 | Bit 15 reset busy, bit 8 clock running |
| card_clk_o | output | 1 | Divided card clock |
| op_start_o | output | 1 | Single-cycle command start pulse |
| aux_pulse_o | output | 4 | Read-wait stop/start, exit-transfer, exit-multiple pulses |

## Verification
The bench uses the default 3-bit divider and a 16-cycle soft reset. With these values it can measure every shift value from 0 to 7, including the widest period of 256 core cycles, within a short run. The stop tests use a 4-cycle high phase, which is long enough to tell a full high phase from a clipped one and to place a stop on either side of a clock edge. The reset length is short enough that the bench can count the busy window cycle by cycle while it writes to the block.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
  localparam int CTRL_REG_W   = 16;
  localparam int CTRL_FIELD_W = 8;
  localparam int DIV_W        = 3;
  localparam int MAX_SHIFT    = (1 << DIV_W) - 1;
  localparam int CNT_W        = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;
  localparam int RST_CYCLES   = 16;
  localparam int AUX_N        = 4;
  // control field positions
  localparam int C_STOP   = 0;
  localparam int C_START  = 1;
  localparam int C_OP     = 2;
  localparam int C_SRST   = 3;
  localparam int C_AUX_LO = 4;
  // status field positions
  localparam int ST_RUN   = 8;
  localparam int ST_BUSY  = 15;
endpackage

// File: rtl/ccc_strobe_decode.sv
module ccc_strobe_decode
  import ccc_pkg::*;
#(
  parameter int FW = CTRL_FIELD_W,
  parameter int AN = AUX_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [FW-1:0] wdata,
  input  logic          busy,
  output logic          stop_req,
  output logic          start_req,
  output logic          srst_req,
  output logic          op_pulse,
  output logic [AN-1:0] aux_pulse
);
  logic take;
  assign take      = wr_en && !busy;
  assign srst_req  = take && wdata[C_SRST];
  assign stop_req  = take && !wdata[C_SRST] && wdata[C_STOP];
  // stop wins over start in the same write
  assign start_req = take && !wdata[C_SRST] && !wdata[C_STOP] && wdata[C_START];

  always_ff @(posedge clk) begin
    if (rst) begin
      op_pulse  <= 1'b0;
      aux_pulse <= '0;
    end else begin
      op_pulse  <= start_req && wdata[C_OP];
      aux_pulse <= (take && !wdata[C_SRST]) ? wdata[C_AUX_LO +: AN] : '0;
    end
  end
endmodule

// File: rtl/ccc_reset_seq.sv
module ccc_reset_seq #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic busy
);
  localparam int W = $clog2(LEN + 1);
  logic [W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      left <= '0;
    end else if (kick) begin
      busy <= 1'b1;
      left <= W'(LEN - 1);
    end else if (busy) begin
      if (left == '0) busy <= 1'b0;
      else            left <= left - W'(1);
    end
  end
endmodule

// File: rtl/ccc_clk_div.sv
module ccc_clk_div
  import ccc_pkg::*;
#(
  parameter int DW = DIV_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          div_wr,
  input  logic [DW-1:0] div_val,
  input  logic          start,
  input  logic          stop,
  output logic          card_clk,
  output logic          running
);
  logic [DW-1:0] div_q, div_act;
  logic [CW-1:0] cnt;
  logic          pend;
  logic [CW:0]   span_m1;
  logic          at_end;

  assign span_m1 = ((CW+1)'(1) << div_act) - (CW+1)'(1);
  assign at_end  = running && (cnt == span_m1[CW-1:0]);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q    <= '0;
      div_act  <= '0;
      running  <= 1'b0;
      card_clk <= 1'b0;
      cnt      <= '0;
      pend     <= 1'b0;
    end else begin
      if (div_wr) div_q <= div_val;
      if (running) begin
        if (at_end) begin
          cnt      <= '0;
          card_clk <= !card_clk;
          if (!card_clk) div_act <= div_q;   // new value at a rising edge
          if (card_clk && pend) begin
            running  <= 1'b0;
            card_clk <= 1'b0;
            pend     <= 1'b0;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
      if (stop && running) begin
        if (!card_clk || at_end) begin
          running  <= 1'b0;
          card_clk <= 1'b0;
          cnt      <= '0;
          pend     <= 1'b0;
        end else begin
          pend <= 1'b1;
        end
      end else if (start && !running) begin
        running  <= 1'b1;
        card_clk <= 1'b0;
        cnt      <= '0;
        pend     <= 1'b0;
        div_act  <= div_q;
      end
    end
  end
endmodule

// File: rtl/card_clk_ctrl.sv
module card_clk_ctrl
  import ccc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ctrl_wr_i,
  input  logic [CTRL_FIELD_W-1:0] ctrl_wdata_i,
  input  logic                    div_wr_i,
  input  logic [DIV_W-1:0]        div_wdata_i,
  output logic [CTRL_REG_W-1:0]   ctrl_rdata_o,
  output logic [CTRL_REG_W-1:0]   status_o,
  output logic                    card_clk_o,
  output logic                    op_start_o,
  output logic [AUX_N-1:0]        aux_pulse_o
);
  logic busy, stop_req, start_req, srst_req, running;

  ccc_strobe_decode #(.FW(CTRL_FIELD_W), .AN(AUX_N)) u_dec (
    .clk(clk), .rst(rst), .wr_en(ctrl_wr_i), .wdata(ctrl_wdata_i), .busy(busy),
    .stop_req(stop_req), .start_req(start_req), .srst_req(srst_req),
    .op_pulse(op_start_o), .aux_pulse(aux_pulse_o)
  );

  ccc_reset_seq #(.LEN(RST_CYCLES)) u_rseq (
    .clk(clk), .rst(rst), .kick(srst_req), .busy(busy)
  );

  ccc_clk_div #(.DW(DIV_W), .CW(CNT_W)) u_div (
    .clk(clk), .rst(rst), .clr(srst_req),
    .div_wr(div_wr_i && !busy), .div_val(div_wdata_i),
    .start(start_req), .stop(stop_req),
    .card_clk(card_clk_o), .running(running)
  );

  always_comb begin
    status_o          = '0;
    status_o[ST_RUN]  = running;
    status_o[ST_BUSY] = busy;
  end

  assign ctrl_rdata_o = '0;
endmodule

// File: rtl/card_clk_ctrl_chk.sv
module card_clk_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        card_clk_o,
  input logic [15:0] status_o,
  input logic        op_start_o,
  input logic [3:0]  aux_pulse_o
);
  assert_stopped_low_R4: assert property (@(posedge clk) disable iff (rst)
    !status_o[8] |-> !card_clk_o);
  assert_op_needs_run_R5: assert property (@(posedge clk) disable iff (rst)
    op_start_o |-> status_o[8]);
  assert_busy_stopped_R6: assert property (@(posedge clk) disable iff (rst)
    status_o[15] |-> (!status_o[8] && !card_clk_o));
  assert_busy_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    status_o[15] |-> (!op_start_o && aux_pulse_o == 4'd0));
  assert_reset_end_idle_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(status_o[15]) |-> !status_o[8]);
endmodule

bind card_clk_ctrl card_clk_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .card_clk_o(card_clk_o), .status_o(status_o),
  .op_start_o(op_start_o), .aux_pulse_o(aux_pulse_o)
);

// File: tb/card_clk_ctrl_bench.sv
module card_clk_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;
  // {divider, expected period in core cycles}
  localparam logic [11:0] VEC [8] = '{
    {3'd0, 9'd2},  {3'd1, 9'd4},  {3'd2, 9'd8},   {3'd3, 9'd16},
    {3'd4, 9'd32}, {3'd5, 9'd64}, {3'd6, 9'd128}, {3'd7, 9'd256}
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic        ctrl_wr = 1'b0, div_wr = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic [2:0]  div_wdata = '0;
  logic [15:0] ctrl_rdata, status;
  logic        card_clk, op_start;
  logic [3:0]  aux;

  int nchk = 0, nfail = 0, ncyc = 0, wd = 0;
  bit prev = 1'b0, cur = 1'b0, done = 1'b0;

  card_clk_ctrl u_card_clk_ctrl (
    .clk(clk), .rst(rst), .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
    .div_wr_i(div_wr), .div_wdata_i(div_wdata), .ctrl_rdata_o(ctrl_rdata),
    .status_o(status), .card_clk_o(card_clk), .op_start_o(op_start),
    .aux_pulse_o(aux)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT && !done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", wd, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    prev = cur; cur = card_clk; ncyc++;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v;
    tick();
    ctrl_wr = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic wr_div(input logic [2:0] v);
    div_wr = 1'b1; div_wdata = v;
    tick();
    div_wr = 1'b0;
  endtask

  task automatic wait_rise(output int at);
    do tick(); while (!(!prev && cur));
    at = ncyc;
  endtask

  task automatic stop_wait();
    wr_ctrl(8'h01);
    while (status[8]) tick();
  endtask

  initial begin
    int t0, t1, n;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // reset state
    chk(status == 16'h0 && !card_clk && !op_start && aux == 4'd0, "R3", int'(status), 0);

    // R1: period for every divider value
    for (int i = 0; i < 8; i++) begin
      stop_wait();
      wr_div(VEC[i][11:9]);
      wr_ctrl(8'h02);
      wait_rise(t0);
      wait_rise(t1);
      chk(t1 - t0 == int'(VEC[i][8:0]), "R1", t1 - t0, int'(VEC[i][8:0]));
    end

    // R1/R2/R3: first rise latency and running flag
    stop_wait();
    chk(!status[8], "R3", int'(status[8]), 0);
    wr_div(3'd2);
    wr_ctrl(8'h02);
    t0 = ncyc;
    chk(status[8], "R2", int'(status[8]), 1);
    wait_rise(t1);
    chk(t1 - t0 == 4, "R1", t1 - t0, 4);

    // R4: stop while high keeps full high phase
    wr_ctrl(8'h01);
    chk(status[8] && cur, "R4", int'(status[8]), 1);
    n = 2;
    tick();
    while (cur) begin n++; tick(); end
    chk(n == 4, "R4", n, 4);
    chk(!status[8], "R3", int'(status[8]), 0);
    n = 0;
    repeat (40) begin tick(); if (cur) n++; end
    chk(n == 0, "R4", n, 0);

    // R4: stop while low is immediate
    wr_div(3'd3);
    wr_ctrl(8'h02);
    wait_rise(t0);
    while (cur) tick();
    wr_ctrl(8'h01);
    chk(!status[8] && !card_clk, "R4", int'(status[8]), 0);

    // R5: op with start, op alone, R8 read-back
    wr_div(3'd1);
    wr_ctrl(8'h06);
    chk(op_start && status[8], "R5", int'(op_start), 1);
    chk(ctrl_rdata == 16'h0, "R8", int'(ctrl_rdata), 0);
    tick();
    chk(!op_start, "R5", int'(op_start), 0);
    wr_ctrl(8'h04);
    chk(!op_start, "R5", int'(op_start), 0);

    // R9: divider change at next rising edge
    wait_rise(t0);
    wr_div(3'd3);
    wait_rise(t1);
    chk(t1 - t0 == 4, "R9", t1 - t0, 4);
    wait_rise(t0);
    chk(t0 - t1 == 16, "R9", t0 - t1, 16);

    // R10: stop and start together
    stop_wait();
    wr_ctrl(8'h07);
    chk(!status[8] && !op_start, "R10", int'(status[8]), 0);

    // R7: auxiliary strobes
    for (int i = 0; i < 4; i++) begin
      wr_ctrl(8'h10 << i);
      chk(aux == 4'(1 << i), "R7", int'(aux), 1 << i);
      tick();
      chk(aux == 4'd0, "R7", int'(aux), 0);
    end

    // R6: soft reset while running, writes ignored during it
    wr_div(3'd5);
    wr_ctrl(8'h02);
    repeat (5) tick();
    wr_ctrl(8'h08);
    n = status[15] ? 1 : 0;
    chk(!status[8] && !card_clk, "R6", int'(status[8]), 0);
    wr_ctrl(8'h02);
    if (status[15]) n++;
    wr_div(3'd6);
    if (status[15]) n++;
    while (status[15]) begin tick(); if (status[15]) n++; end
    chk(n == 16, "R6", n, 16);
    chk(!status[8], "R6", int'(status[8]), 0);
    wr_ctrl(8'h02);
    wait_rise(t0);
    wait_rise(t1);
    chk(t1 - t0 == 2, "R6", t1 - t0, 2);
    chk(ctrl_rdata == 16'h0, "R8", int'(ctrl_rdata), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule